// File: doc/BRIEF.md
# Two-Character-per-Cycle One-Hot Pattern Automaton

This block scans a byte stream for five fixed patterns and raises a flag for each pattern it has seen. The patterns are `ab+cd`, `ab+ce`, `ab+c.*f`, `b[d-f]a` and `bdc`. Each one is written as a small nondeterministic automaton. Every automaton state is a single flip-flop, and any number of these flip-flops may be set at the same time. The block takes two characters on each clock where the valid bit is high. A decode stage sorts each character into the classes the patterns need. The update logic then moves every active state through the earlier character and then through the later one, all within the same cycle.

The patterns share prefixes, but each pattern keeps its own chain of states. Transitions on the same symbol are never merged, so no combined states exist. The starting point is always active, so a pattern may begin on either character of a pair. An accept is evaluated after each of the two characters. A pattern that completes on the earlier character is therefore not lost when the later character moves the automaton on. Once a flag is set, it stays set until reset.

Top module: `strideNfaMatcher`

## Requirements
- R1: After reset, all automaton states are inactive and all five match flags read 0.
- R2: Characters are compared case-sensitively against lowercase ASCII. An uppercase letter never advances any pattern.
- R3: Each cycle with `inValid` high consumes two characters. The earlier character is `inPair[15:8]` and the later one is `inPair[7:0]`. The flags reflect that pair after the same clock edge.
- R4: A pattern may begin at either character position of a pair.
- R5: A pattern completing on the earlier character of a pair sets its flag, whatever the later character is.
- R6: The flag bits are assigned as follows: bit0 = `ab+cd`, bit1 = `ab+ce`, bit2 = `ab+c.*f`, bit3 = `b[d-f]a`, bit4 = `bdc`.
- R7: The `b+` term accepts one or more consecutive `b` characters, including runs that span pairs.
- R8: In `ab+c.*f`, any characters (including none) may lie between the `c` and the `f`.
- R9: While `inValid` is low, the states and flags hold their values and the input data is ignored.
- R10: A set flag stays set until reset, regardless of later input.
- R11: The patterns are tracked independently. One input stream may set several flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Pair on `inPair` is consumed this cycle |
| inPair | input | 16 | Two characters; earlier one in the upper byte |
| matchFlags | output | 5 | Sticky per-pattern match flags |

## Verification
The bench aims at patterns that complete on the earlier character of a pair. A design that only tested accepts after the second character would miss those matches. It also splits the `b+` run and the `.*` gap across pair boundaries. A design that dropped the self-loops would then lose the match. Idle cycles carrying garbage data are placed mid-pattern, which exposes a design that advances without valid. Uppercase input and a reset taken mid-pattern check that no stale or case-folded state produces a false flag.

// File: rtl/nfaPkg.sv
package nfaPkg;
  localparam int CHAR_W    = 8;
  localparam int STRIDE    = 2;
  localparam int NUM_RULES = 5;
  localparam int PAIR_W    = CHAR_W * STRIDE;

  typedef struct packed {
    logic isA;
    logic isB;
    logic isC;
    logic isD;
    logic isE;
    logic isF;
    logic isDtoF;
  } charClass_t;

  typedef struct packed {
    logic r0a, r0b, r0c;
    logic r1a, r1b, r1c;
    logic r2a, r2b, r2c;
    logic r3b, r3m;
    logic r4b, r4d;
  } nfaState_t;

  typedef struct packed {
    logic stepState;
    logic loadFlags;
  } ctrlStrobe_t;

  function automatic nfaState_t stepNfa(nfaState_t s, charClass_t k);
    nfaState_t n;
    n.r0a = k.isA;
    n.r0b = (s.r0a | s.r0b) & k.isB;
    n.r0c = s.r0b & k.isC;
    n.r1a = k.isA;
    n.r1b = (s.r1a | s.r1b) & k.isB;
    n.r1c = s.r1b & k.isC;
    n.r2a = k.isA;
    n.r2b = (s.r2a | s.r2b) & k.isB;
    n.r2c = (s.r2b & k.isC) | s.r2c;
    n.r3b = k.isB;
    n.r3m = s.r3b & k.isDtoF;
    n.r4b = k.isB;
    n.r4d = s.r4b & k.isD;
    return n;
  endfunction

  function automatic logic [NUM_RULES-1:0] acceptNfa(nfaState_t s, charClass_t k);
    logic [NUM_RULES-1:0] acc;
    acc[0] = s.r0c & k.isD;
    acc[1] = s.r1c & k.isE;
    acc[2] = s.r2c & k.isF;
    acc[3] = s.r3m & k.isA;
    acc[4] = s.r4d & k.isC;
    return acc;
  endfunction
endpackage

// File: rtl/charClassDecode.sv
module charClassDecode
  import nfaPkg::*;
#(
  parameter int W = CHAR_W
) (
  input  logic [W-1:0] ch,
  output charClass_t   cls
);
  // R2: exact lowercase compares only
  always_comb begin
    cls.isA    = (ch == W'(8'h61));
    cls.isB    = (ch == W'(8'h62));
    cls.isC    = (ch == W'(8'h63));
    cls.isD    = (ch == W'(8'h64));
    cls.isE    = (ch == W'(8'h65));
    cls.isF    = (ch == W'(8'h66));
    cls.isDtoF = (ch >= W'(8'h64)) && (ch <= W'(8'h66));
  end
endmodule

// File: rtl/nfaControl.sv
module nfaControl
  import nfaPkg::*;
(
  input  logic        inValid,
  output ctrlStrobe_t strobe
);
  // R9: nothing moves unless a pair is presented
  always_comb begin
    strobe.stepState = inValid;
    strobe.loadFlags = inValid;
  end
endmodule

// File: rtl/nfaDatapath.sv
module nfaDatapath
  import nfaPkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobe_t          strobe,
  input  logic [PAIR_W-1:0]    inPair,
  output logic [NUM_RULES-1:0] matchFlags
);
  charClass_t           cls [STRIDE];
  nfaState_t            stateQ;
  nfaState_t            chain [STRIDE+1];
  logic [NUM_RULES-1:0] accAny;
  logic [NUM_RULES-1:0] matchQ;

  // position 0 is the earlier character, carried in the upper byte (R3)
  for (genvar g = 0; g < STRIDE; g++) begin : gDecode
    charClassDecode #(.W(CHAR_W)) uDec (
      .ch  (inPair[(STRIDE-g)*CHAR_W-1 -: CHAR_W]),
      .cls (cls[g])
    );
  end

  // R5: accept checked after each character, not only the last
  always_comb begin
    chain[0] = stateQ;
    accAny   = '0;
    for (int p = 0; p < STRIDE; p++) begin
      accAny       = accAny | acceptNfa(chain[p], cls[p]);
      chain[p+1]   = stepNfa(chain[p], cls[p]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ <= '0;
      matchQ <= '0;
    end else begin
      if (strobe.stepState) stateQ <= chain[STRIDE];
      if (strobe.loadFlags) matchQ <= matchQ | accAny;
    end
  end

  assign matchFlags = matchQ;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.stepState |=> $stable(stateQ)); // R9
  AST_IDLE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadFlags |=> $stable(matchQ)); // R9
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (matchQ != '0) |=> ((matchQ & $past(matchQ)) == $past(matchQ))); // R10
  AST_DOTSTAR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ.r2c && strobe.stepState) |=> stateQ.r2c); // R8
  AST_BPLUS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ.r0b && strobe.stepState && cls[0].isB && cls[1].isB) |=> stateQ.r0b); // R7
  AST_MID_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (stateQ.r3m && strobe.loadFlags && cls[0].isA) |=> matchQ[3]); // R5
endmodule

// File: rtl/strideNfaMatcher.sv
module strideNfaMatcher
  import nfaPkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inValid,
  input  logic [PAIR_W-1:0]    inPair,
  output logic [NUM_RULES-1:0] matchFlags
);
  ctrlStrobe_t strobe;

  nfaControl uCtrl (
    .inValid (inValid),
    .strobe  (strobe)
  );

  nfaDatapath uData (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .inPair     (inPair),
    .matchFlags (matchFlags)
  );
endmodule

// File: tb/tb_strideNfaMatcher.sv
module tb_strideNfaMatcher;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [15:0] inPair = 16'h7a7a;
  logic [4:0]  matchFlags;
  int checks = 0;
  int errors = 0;

  strideNfaMatcher dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid),
    .inPair(inPair), .matchFlags(matchFlags)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic [63:0] text;
    logic [2:0]  pairs;
    logic [4:0]  exp;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{"abcdzzzz", 3'd2, 5'b00001},  // R6 R3 end on later char
    '{"zabbbcez", 3'd4, 5'b00010},  // R7 R5 R4
    '{"abcxxfzz", 3'd3, 5'b00100},  // R8
    '{"zbeazzzz", 3'd2, 5'b01000},  // R4 R6
    '{"bdczzzzz", 3'd2, 5'b10000},  // R5 R6
    '{"abcdfzzz", 3'd3, 5'b00101},  // R11
    '{"acdzzzzz", 3'd2, 5'b00000},  // no match
    '{"bdazzzzz", 3'd2, 5'b01000},  // R5
    '{"AbcdzzzZ", 3'd2, 5'b00000}   // R2
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    inValid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic sendPair(input logic [15:0] p, input logic v);
    @(negedge clk);
    inPair = p;
    inValid = v;
  endtask

  task automatic settle();
    @(negedge clk);
    inValid = 1'b0;
    inPair = 16'h7a7a;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 reset flags", matchFlags, 5'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      doReset();
      for (int p = 0; p < int'(VECS[i].pairs); p++)
        sendPair(VECS[i].text[63-16*p -: 16], 1'b1);
      settle();
      check($sformatf("R3 vector %0d", i), matchFlags, VECS[i].exp);
    end

    // R9: idle cycle carrying garbage in mid-pattern is ignored
    doReset();
    sendPair("ab", 1'b1);
    sendPair("zz", 1'b0);
    sendPair("zz", 1'b0);
    sendPair("cd", 1'b1);
    settle();
    check("R9 idle hold", matchFlags, 5'b00001);

    // R9: idle cycle with would-be completing data sets nothing
    doReset();
    sendPair("bd", 1'b1);
    sendPair("cz", 1'b0);
    settle();
    check("R9 idle ignored", matchFlags, 5'b00000);

    // R10: flag stays set after unrelated traffic
    sendPair("cz", 1'b1);
    settle();
    check("R10 set", matchFlags, 5'b10000);
    for (int k = 0; k < 4; k++) sendPair("zz", 1'b1);
    settle();
    check("R10 sticky", matchFlags, 5'b10000);

    // R1: reset mid-pattern clears the states
    doReset();
    sendPair("ab", 1'b1);
    settle();
    doReset();
    sendPair("cd", 1'b1);
    settle();
    check("R1 reset clears state", matchFlags, 5'b00000);

    // R8: .* gap spanning several pairs, including c and d
    doReset();
    sendPair("za", 1'b1);
    sendPair("bc", 1'b1);
    sendPair("qq", 1'b1);
    sendPair("dc", 1'b1);
    sendPair("fz", 1'b1);
    settle();
    check("R8 long gap", matchFlags, 5'b00100);

    // R7: b run across three pairs, completion on later char
    doReset();
    sendPair("ab", 1'b1);
    sendPair("bb", 1'b1);
    sendPair("bb", 1'b1);
    sendPair("ce", 1'b1);
    settle();
    check("R7 long b run", matchFlags, 5'b00010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule